// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise and Overrun Flags

This block recovers asynchronous serial frames from a single receive line. It waits in idle for the line to fall from high to low, which marks the start bit. It then counts sample ticks and takes three samples around the centre of every bit. The bit value is the majority of the three samples. A frame is one start bit, 8 or 9 data bits sent least significant bit first, an optional parity bit and one stop bit. Once the stop bit has been sampled, the word moves into a one-entry receive register.

The receive register faces downstream as a valid/ready stream. `out_valid` means the register holds an unread word. That word, together with its noise and parity flags, stays unchanged for as long as `out_ready` is low. A transfer takes place on any clock edge where `out_valid` and `out_ready` are both high, and the register is empty on the next cycle. If a new frame completes while the register is still full, the unread word is kept, the new word is dropped, and the overrun flag is raised until the next transfer.

The sample tick is a one-cycle enable that runs at 16 or 8 times the bit rate, chosen by `cfg_os8`. The line passes through a synchronizer before it is used.

Top module: `os_uart_rx`

## Requirements
- R1: After reset, `out_valid`, `out_noise`, `out_perr` and `out_overrun` are all 0.
- R2: A frame starts only on a high-to-low change of the line. If the start bit does not read low by majority at mid-bit, the receiver returns to idle and delivers no word. A later valid frame is then received normally.
- R3: With `cfg_nine_bit`=0, eight data bits are received least significant bit first into `out_data[7:0]`, and `out_data[8]` is 0.
- R4: With `cfg_nine_bit`=1, nine data bits are received least significant bit first into `out_data[8:0]`.
- R5: With `cfg_os8`=0 a bit lasts 16 ticks and is sampled at ticks 7, 8 and 9. With `cfg_os8`=1 a bit lasts 8 ticks and is sampled at ticks 3, 4 and 5. Tick 0 of the start bit is the tick on which the falling edge is seen.
- R6: Each bit takes the majority value of its three samples. If the three samples of any bit in the frame disagree, `out_noise` is 1 alongside the word, and the word is still delivered. A clean frame gives `out_noise`=0.
- R7: `out_valid` rises only after the stop bit has been sampled. While `out_ready` is low it stays high and the word does not change. After a transfer it is 0 on the next cycle.
- R8: If a frame completes while `out_valid`=1 and no transfer happens on that cycle, the held word is kept and `out_overrun` becomes 1. A transfer clears `out_overrun`.
- R9: With `cfg_par_en`=1, one parity bit follows the data bits. `cfg_par_odd`=0 selects even parity: data plus parity bit hold an even number of ones. `cfg_par_odd`=1 selects odd parity. On a mismatch, `out_perr` is 1 alongside the delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Oversampling enable, one cycle per tick |
| rx_line | input | 1 | Serial receive line, idle high |
| cfg_nine_bit | input | 1 | 1: nine data bits, 0: eight |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_os8 | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| out_ready | input | 1 | Downstream accepts the held word |
| out_valid | output | 1 | Receive register holds an unread word |
| out_data | output | 9 | Received data word |
| out_noise | output | 1 | Sample disagreement seen in the held word's frame |
| out_perr | output | 1 | Parity mismatch in the held word's frame |
| out_overrun | output | 1 | A frame was dropped because the register was full |

## Verification
The bench builds the block with its default parameters: 16 and 8 ticks per bit and a two-stage synchronizer. It holds `sample_tick` high on every clock, so each tick is one cycle and the bench can place a single-cycle disturbance on exactly one of the three sample points of a chosen bit. In both oversampling modes, this brings the majority vote, the noise flag, start-bit glitch rejection and the exact sampling windows within reach. Overrun and back-pressure are covered by sending frames back to back while `out_ready` is held low.

// File: rtl/orx_pkg.sv
package orx_pkg;
  localparam int RX_WORD_MAX = 9;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [RX_WORD_MAX-1:0] data;
    logic                   noise;
    logic                   perr;
  } rx_word_t;
endpackage

// File: rtl/orx_sync.sv
module orx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/orx_vote.sv
module orx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic din,
  output logic maj,
  output logic noisy
);
  logic first_q;
  logic second_q;

  // The first two samples are kept in registers and the third is the live value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else if (take) begin
      first_q  <= second_q;
      second_q <= din;
    end
  end

  always_comb begin
    maj   = (first_q & second_q) | (first_q & din) | (second_q & din);
    noisy = !((first_q == second_q) && (second_q == din));
  end
endmodule

// File: rtl/orx_frame.sv
module orx_frame
  import orx_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic     cfg_nine,
  input  logic     cfg_par_en,
  input  logic     cfg_par_odd,
  input  logic     cfg_os8,
  output logic     done,
  output rx_word_t word
);
  localparam int CNT_W = $clog2(OS_HI);
  localparam int BIT_W = $clog2(RX_WORD_MAX);
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(OS_HI - 1);
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(OS_LO - 1);
  localparam logic [CNT_W-1:0] HI_MID  = CNT_W'(OS_HI / 2);
  localparam logic [CNT_W-1:0] LO_MID  = CNT_W'(OS_LO / 2);
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(RX_WORD_MAX - 1);
  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(RX_WORD_MAX - 2);

  rx_state_e              state;
  logic [CNT_W-1:0]       cnt;
  logic [BIT_W-1:0]       bitn;
  logic [RX_WORD_MAX-1:0] sh;
  logic                   par_acc;
  logic                   noise_acc;
  logic                   line_prev;

  logic [CNT_W-1:0] os_last;
  logic [CNT_W-1:0] mid;
  logic [BIT_W-1:0] last_bit;
  logic             busy;
  logic             take;
  logic             decide;
  logic             maj;
  logic             noisy;

  always_comb begin
    os_last  = cfg_os8 ? LO_LAST : HI_LAST;
    mid      = cfg_os8 ? LO_MID : HI_MID;
    last_bit = cfg_nine ? LAST_WIDE : LAST_NARROW;
    busy     = (state != ST_IDLE);
    take     = tick && busy && ((cnt == mid - 1'b1) || (cnt == mid));
    decide   = tick && busy && (cnt == mid + 1'b1);
  end

  orx_vote u_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .din   (line),
    .maj   (maj),
    .noisy (noisy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sh        <= '0;
      par_acc   <= 1'b0;
      noise_acc <= 1'b0;
      line_prev <= 1'b1;
      done      <= 1'b0;
      word      <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          line_prev <= line;
          if (line_prev && !line) begin
            // The detecting tick is tick 0 of the start bit.
            state     <= ST_START;
            cnt       <= CNT_W'(1);
            bitn      <= '0;
            par_acc   <= 1'b0;
            noise_acc <= 1'b0;
          end
        end else begin
          cnt <= (cnt == os_last) ? '0 : cnt + 1'b1;
          if (decide) begin
            case (state)
              ST_START: begin
                if (maj) begin
                  state     <= ST_IDLE;
                  line_prev <= line;
                end else begin
                  noise_acc <= noise_acc | noisy;
                end
              end
              ST_DATA: begin
                sh        <= {maj, sh[RX_WORD_MAX-1:1]};
                par_acc   <= par_acc ^ maj;
                noise_acc <= noise_acc | noisy;
              end
              ST_PAR: begin
                par_acc   <= par_acc ^ maj;
                noise_acc <= noise_acc | noisy;
              end
              ST_STOP: begin
                done       <= 1'b1;
                word.data  <= cfg_nine ? sh : {1'b0, sh[RX_WORD_MAX-1:1]};
                word.noise <= noise_acc | noisy;
                word.perr  <= cfg_par_en & (par_acc ^ cfg_par_odd);
                state      <= ST_IDLE;
                line_prev  <= line;
              end
              default: ;
            endcase
          end else if (cnt == os_last) begin
            case (state)
              ST_START: state <= ST_DATA;
              ST_DATA: begin
                if (bitn == last_bit) state <= cfg_par_en ? ST_PAR : ST_STOP;
                else                  bitn  <= bitn + 1'b1;
              end
              ST_PAR:  state <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (cnt <= os_last));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));
endmodule

// File: rtl/orx_hold.sv
module orx_hold
  import orx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  rx_word_t in_word,
  input  logic     ready,
  output logic     valid,
  output rx_word_t word,
  output logic     ovr
);
  logic accept;

  assign accept = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
      ovr   <= 1'b0;
    end else begin
      if (accept) begin
        valid <= 1'b0;
        ovr   <= 1'b0;
      end
      if (load) begin
        if (valid && !accept) begin
          ovr <= 1'b1;
        end else begin
          word  <= in_word;
          valid <= 1'b1;
        end
      end
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(word)));

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> (!valid && !ovr));

  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid && !ready) |=> (ovr && $stable(word)));
endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
  import orx_pkg::*;
#(
  parameter int OS_HI       = 16,
  parameter int OS_LO       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_tick,
  input  logic                   rx_line,
  input  logic                   cfg_nine_bit,
  input  logic                   cfg_par_en,
  input  logic                   cfg_par_odd,
  input  logic                   cfg_os8,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [RX_WORD_MAX-1:0] out_data,
  output logic                   out_noise,
  output logic                   out_perr,
  output logic                   out_overrun
);
  logic     line_s;
  logic     frame_done;
  rx_word_t frame_word;
  rx_word_t held;

  orx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .dout  (line_s)
  );

  orx_frame #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (sample_tick),
    .line        (line_s),
    .cfg_nine    (cfg_nine_bit),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_os8     (cfg_os8),
    .done        (frame_done),
    .word        (frame_word)
  );

  orx_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frame_done),
    .in_word (frame_word),
    .ready   (out_ready),
    .valid   (out_valid),
    .word    (held),
    .ovr     (out_overrun)
  );

  assign out_data  = held.data;
  assign out_noise = held.noise;
  assign out_perr  = held.perr;
endmodule

// File: tb/os_uart_rx_test.sv
module os_uart_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b1;
  logic       rx_line = 1'b1;
  logic       cfg_nine_bit = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_os8 = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [8:0] out_data;
  logic       out_noise;
  logic       out_perr;
  logic       out_overrun;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  os_uart_rx uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_tick  (sample_tick),
    .rx_line      (rx_line),
    .cfg_nine_bit (cfg_nine_bit),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_os8      (cfg_os8),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_noise    (out_noise),
    .out_perr     (out_perr),
    .out_overrun  (out_overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One frame, one tick per clock; gbit counts the start bit as 0.
  task automatic send_frame(input logic [8:0] d, input int nb, input bit pe, input bit po,
                            input bit pflip, input int os, input int gbit, input int gtick,
                            input bit pre_chk);
    logic [11:0] fr;
    logic        p;
    int          n;
    fr    = '0;
    fr[0] = 1'b0;
    p     = po;
    for (int i = 0; i < nb; i++) begin
      fr[i+1] = d[i];
      p       = p ^ d[i];
    end
    n = nb + 1;
    if (pe) begin
      fr[n] = pflip ? ~p : p;
      n++;
    end
    fr[n] = 1'b1;
    n++;
    for (int b = 0; b < n; b++) begin
      if (pre_chk && b == n - 1) check("R7 valid before stop", 32'(out_valid), 32'd0);
      for (int t = 0; t < os; t++) begin
        @(negedge clk);
        rx_line = (b == gbit && t == gtick) ? ~fr[b] : fr[b];
      end
    end
    @(negedge clk);
    rx_line = 1'b1;
    repeat (os) @(negedge clk);
  endtask

  task automatic read_word();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(out_valid), 32'd0);
    check("R1 noise", 32'(out_noise), 32'd0);
    check("R1 perr", 32'(out_perr), 32'd0);
    check("R1 overrun", 32'(out_overrun), 32'd0);
  endtask

  task automatic t_basic();
    send_frame(9'h0A5, 8, 0, 0, 0, 16, -1, 0, 1);
    check("R7 valid after stop", 32'(out_valid), 32'd1);
    check("R3 data A5", 32'(out_data), 32'h0A5);
    check("R6 clean noise", 32'(out_noise), 32'd0);
    repeat (6) @(negedge clk);
    check("R7 held valid", 32'(out_valid), 32'd1);
    check("R7 held data", 32'(out_data), 32'h0A5);
    read_word();
    check("R7 drained", 32'(out_valid), 32'd0);
    send_frame(9'h080, 8, 0, 0, 0, 16, -1, 0, 0);
    check("R3 msb only", 32'(out_data), 32'h080);
    read_word();
  endtask

  task automatic t_nine();
    cfg_nine_bit = 1'b1;
    send_frame(9'h1A5, 9, 0, 0, 0, 16, -1, 0, 0);
    check("R4 valid", 32'(out_valid), 32'd1);
    check("R4 data 1A5", 32'(out_data), 32'h1A5);
    read_word();
    cfg_nine_bit = 1'b0;
  endtask

  task automatic t_os8();
    cfg_os8 = 1'b1;
    send_frame(9'h03C, 8, 0, 0, 0, 8, -1, 0, 1);
    check("R5 valid 8x", 32'(out_valid), 32'd1);
    check("R5 data 8x", 32'(out_data), 32'h03C);
    read_word();
    // disturbance on tick 4 of data bit 0: middle sample of 3,4,5
    send_frame(9'h0F0, 8, 0, 0, 0, 8, 1, 4, 0);
    check("R5 data 8x glitch", 32'(out_data), 32'h0F0);
    check("R5 noise at tick 4", 32'(out_noise), 32'd1);
    read_word();
    // disturbance on tick 6 is outside the window
    send_frame(9'h0F0, 8, 0, 0, 0, 8, 1, 6, 0);
    check("R5 no noise at tick 6", 32'(out_noise), 32'd0);
    read_word();
    cfg_os8 = 1'b0;
  endtask

  task automatic t_noise();
    send_frame(9'h0C3, 8, 0, 0, 0, 16, 4, 8, 0);
    check("R6 data kept", 32'(out_data), 32'h0C3);
    check("R6 noise set", 32'(out_noise), 32'd1);
    read_word();
    send_frame(9'h0C3, 8, 0, 0, 0, 16, 4, 9, 0);
    check("R5 noise at tick 9", 32'(out_noise), 32'd1);
    read_word();
    send_frame(9'h0C3, 8, 0, 0, 0, 16, 4, 11, 0);
    check("R6 clean again", 32'(out_noise), 32'd0);
    read_word();
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 glitch no word", 32'(out_valid), 32'd0);
    send_frame(9'h05A, 8, 0, 0, 0, 16, -1, 0, 0);
    check("R2 recover data", 32'(out_data), 32'h05A);
    read_word();
  endtask

  task automatic t_parity();
    cfg_par_en = 1'b1;
    cfg_par_odd = 1'b0;
    send_frame(9'h055, 8, 1, 0, 0, 16, -1, 0, 0);
    check("R9 even ok", 32'(out_perr), 32'd0);
    read_word();
    send_frame(9'h055, 8, 1, 0, 1, 16, -1, 0, 0);
    check("R9 even bad", 32'(out_perr), 32'd1);
    check("R9 data kept", 32'(out_data), 32'h055);
    read_word();
    cfg_par_odd = 1'b1;
    send_frame(9'h007, 8, 1, 1, 0, 16, -1, 0, 0);
    check("R9 odd ok", 32'(out_perr), 32'd0);
    read_word();
    send_frame(9'h007, 8, 1, 1, 1, 16, -1, 0, 0);
    check("R9 odd bad", 32'(out_perr), 32'd1);
    read_word();
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 8, 0, 0, 0, 16, -1, 0, 0);
    check("R8 no overrun yet", 32'(out_overrun), 32'd0);
    send_frame(9'h022, 8, 0, 0, 0, 16, -1, 0, 0);
    check("R8 valid", 32'(out_valid), 32'd1);
    check("R8 old word kept", 32'(out_data), 32'h011);
    check("R8 overrun set", 32'(out_overrun), 32'd1);
    read_word();
    check("R8 drained", 32'(out_valid), 32'd0);
    check("R8 overrun cleared", 32'(out_overrun), 32'd0);
    send_frame(9'h033, 8, 0, 0, 0, 16, -1, 0, 0);
    check("R8 next word", 32'(out_data), 32'h033);
    check("R8 no overrun", 32'(out_overrun), 32'd0);
    read_word();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_nine();
    t_os8();
    t_noise();
    t_glitch();
    t_parity();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule